// File: doc/BRIEF.md
# CCD Exposure and Flush Sequencer

This block produces the digital timing for an interline-transfer CCD sensor: a frame-transfer clock, a vertical-transfer clock, a horizontal-transfer clock and an electronic-shutter control. While no capture is wanted it keeps the sensor clean. It runs flush passes back to back. Each pass opens with a single frame-transfer pulse and then drives the vertical and horizontal clocks in lockstep, with the shutter held in its charge-dump state. The video output is not valid during a flush.

A capture request is latched. The flush pass in progress is allowed to finish, and an optional second clearing pass can be added by a configuration input. The block then stops every transfer clock, opens the shutter and times the programmed exposure. It ends the exposure with one frame-transfer pulse and closes the shutter. Readout follows. For each line there is one vertical pulse, then one horizontal pulse per pixel, all at a rate divided down from the system clock. A one-cycle sample strobe marks the settled half of every horizontal period. Busy and done outputs frame the capture.

Top module: `ccd_timing_seq`

## Requirements
- R1: Every flush pass begins with exactly one frame-transfer pulse that is high for a single cycle; a frame-transfer pulse is never high on two consecutive cycles.
- R2: The shutter output stays low (closed, dumping charge) in reset, during every flush pass and during readout.
- R3: During a flush the vertical and horizontal clocks are equal on every cycle and toggle every cycle. A pass issues 2*N vertical pulses, where N is `n_lines` and a value of zero counts as one.
- R4: While no capture is pending, flush passes repeat without gaps. Consecutive frame-transfer pulses are 4*N+1 cycles apart.
- R5: A request arriving mid-flush is latched, and `busy` is high on the cycle after the request is sampled. The current pass completes and exposure starts with no further frame-transfer pulse when `clear_twice` is 0.
- R6: With `clear_twice` at 1, exactly one extra flush pass (one frame-transfer pulse) runs between the request and the exposure.
- R7: The shutter is high for E+1 cycles, where E is `exp_len` and a value of zero counts as one. During that window the vertical and horizontal clocks stay low, and the frame-transfer clock is high only on the last open cycle.
- R8: Readout issues one vertical pulse per line, and after each vertical pulse one horizontal pulse per pixel. The totals are L vertical pulses and L*P horizontal pulses, where L is `n_lines` and P is `n_pix`, each with zero counting as one.
- R9: Every high and low half of a readout vertical or horizontal pulse lasts `rate_div`+1 cycles.
- R10: `pix_strobe` pulses for one cycle per pixel, on the first cycle of the low half of the horizontal pulse that follows a high half.
- R11: `done` is high for exactly one cycle after the last pixel of the last line, and `busy` falls on that same cycle.
- R12: A capture request made while `busy` is high is ignored, so no second exposure follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_req | input | 1 | Capture request, sampled each cycle |
| exp_len | input | EXP_W | Exposure length in cycles (0 counts as 1) |
| n_lines | input | LINE_W | Sensor line count (0 counts as 1) |
| n_pix | input | PIX_W | Pixels per line (0 counts as 1) |
| rate_div | input | DIV_W | Readout half-period minus one, in cycles |
| clear_twice | input | 1 | Run one extra clearing pass before exposure |
| ft_clk | output | 1 | Frame-transfer clock |
| v_clk | output | 1 | Vertical-transfer clock |
| h_clk | output | 1 | Horizontal-transfer clock |
| shutter_open | output | 1 | High: shutter open; low: charge dumped |
| pix_strobe | output | 1 | One-cycle sample strobe per pixel |
| busy | output | 1 | High from request acceptance to end of readout |
| done | output | 1 | One-cycle pulse at end of readout |

## Verification
The hardest situation to reach is a request that lands in the middle of a flush pass. The bench must then show that the pass finishes without a fresh frame-transfer pulse, or with exactly one when the extra clearing pass is selected. The stimulus first waits for a frame-transfer pulse at the ports and then raises the request a few cycles later, so it always falls inside a pass. A second awkward case is a request during readout. It is driven partway through the pixel stream, and the bench then watches two full flush periods for any shutter opening.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [2:0] {
        ST_START,
        ST_FT,
        ST_FLUSH,
        ST_EXPOSE,
        ST_XFER,
        ST_RDV,
        ST_RDH,
        ST_DONE
    } seq_st_e;

    typedef struct packed {
        logic ft;
        logic vclk;
        logic hclk;
        logic shut;
        logic strobe;
    } ccd_drv_t;

    // Maps sequencer state and phase onto the sensor drive lines.
    function automatic ccd_drv_t drive_of(seq_st_e st, logic ph, logic flush_hi, logic first);
        ccd_drv_t d;
        d = '0;
        case (st)
            ST_FT:     d.ft = 1'b1;
            ST_FLUSH:  begin d.vclk = flush_hi; d.hclk = flush_hi; end
            ST_EXPOSE: d.shut = 1'b1;
            ST_XFER:   begin d.ft = 1'b1; d.shut = 1'b1; end
            ST_RDV:    d.vclk = ~ph;
            ST_RDH:    begin d.hclk = ~ph; d.strobe = ph & first; end
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ccd_rate_tick.sv
module ccd_rate_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             first
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (cnt == div)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick  = en && (cnt == div);
    assign first = en && (cnt == '0);

    // after a period ends, the next period starts at its first cycle
    assert_tick_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (en && tick) |=> (!en || first));

endmodule

// File: rtl/ccd_seq_fsm.sv
module ccd_seq_fsm
    import ccd_seq_pkg::*;
#(
    parameter int EXP_W  = 16,
    parameter int LINE_W = 8,
    parameter int PIX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_req,
    input  logic [EXP_W-1:0]  exp_len,
    input  logic [LINE_W-1:0] n_lines,
    input  logic [PIX_W-1:0]  n_pix,
    input  logic              clear_twice,
    input  logic              tick,
    input  logic              first,
    output logic              rd_en,
    output ccd_drv_t          drv,
    output logic              busy,
    output logic              done
);
    localparam int FL_W = LINE_W + 2;

    seq_st_e           st;
    logic              ph;
    logic              pend;
    logic              extra;
    logic [FL_W-1:0]   fcnt;
    logic [EXP_W-1:0]  ecnt;
    logic [LINE_W-1:0] line;
    logic [PIX_W-1:0]  pix;

    logic [LINE_W-1:0] nl_eff;
    logic [PIX_W-1:0]  np_eff;
    logic [EXP_W-1:0]  el_eff;
    logic [FL_W-1:0]   flush_last;

    assign nl_eff     = (n_lines == '0) ? LINE_W'(1) : n_lines;
    assign np_eff     = (n_pix == '0)   ? PIX_W'(1)  : n_pix;
    assign el_eff     = (exp_len == '0) ? EXP_W'(1)  : exp_len;
    assign flush_last = {nl_eff, 2'b00} - FL_W'(1);

    assign busy  = pend || (st == ST_EXPOSE) || (st == ST_XFER) ||
                   (st == ST_RDV) || (st == ST_RDH);
    assign done  = (st == ST_DONE);
    assign rd_en = (st == ST_RDV) || (st == ST_RDH);
    assign drv   = drive_of(st, ph, ~fcnt[0], first);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_START;
            ph    <= 1'b0;
            pend  <= 1'b0;
            extra <= 1'b0;
            fcnt  <= '0;
            ecnt  <= '0;
            line  <= '0;
            pix   <= '0;
        end else begin
            if (cap_req && !busy)
                pend <= 1'b1;
            case (st)
                ST_START: st <= ST_FT;
                ST_FT: begin
                    st   <= ST_FLUSH;
                    fcnt <= '0;
                end
                ST_FLUSH: begin
                    if (fcnt == flush_last) begin
                        if (pend && clear_twice && !extra) begin
                            extra <= 1'b1;
                            st    <= ST_FT;
                        end else if (pend) begin
                            pend  <= 1'b0;
                            extra <= 1'b0;
                            ecnt  <= '0;
                            st    <= ST_EXPOSE;
                        end else begin
                            st <= ST_FT;
                        end
                    end else begin
                        fcnt <= fcnt + 1'b1;
                    end
                end
                ST_EXPOSE: begin
                    if (ecnt == el_eff - EXP_W'(1))
                        st <= ST_XFER;
                    else
                        ecnt <= ecnt + 1'b1;
                end
                ST_XFER: begin
                    st   <= ST_RDV;
                    ph   <= 1'b0;
                    line <= '0;
                    pix  <= '0;
                end
                ST_RDV: begin
                    if (tick) begin
                        if (ph) begin
                            ph  <= 1'b0;
                            pix <= '0;
                            st  <= ST_RDH;
                        end else begin
                            ph <= 1'b1;
                        end
                    end
                end
                ST_RDH: begin
                    if (tick) begin
                        if (!ph) begin
                            ph <= 1'b1;
                        end else begin
                            ph <= 1'b0;
                            if (pix == np_eff - PIX_W'(1)) begin
                                if (line == nl_eff - LINE_W'(1)) begin
                                    st <= ST_DONE;
                                end else begin
                                    line <= line + 1'b1;
                                    st   <= ST_RDV;
                                end
                            end else begin
                                pix <= pix + 1'b1;
                            end
                        end
                    end
                end
                ST_DONE: st <= ST_FT;
                default: st <= ST_START;
            endcase
        end
    end

    assert_ft_single_R1: assert property (@(posedge clk) disable iff (rst)
        drv.ft |=> !drv.ft);

    assert_flush_shut_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FLUSH || rd_en) |-> !drv.shut);

    assert_flush_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FLUSH && $past(st) == ST_FLUSH) |-> (drv.vclk != $past(drv.vclk)));

    assert_expose_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        drv.shut |-> (!drv.vclk && !drv.hclk));

    assert_strobe_settled_R10: assert property (@(posedge clk) disable iff (rst)
        drv.strobe |-> (!drv.hclk && $past(drv.hclk)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_end_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

// File: rtl/ccd_timing_seq.sv
module ccd_timing_seq
    import ccd_seq_pkg::*;
#(
    parameter int EXP_W  = 16,
    parameter int LINE_W = 8,
    parameter int PIX_W  = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_req,
    input  logic [EXP_W-1:0]  exp_len,
    input  logic [LINE_W-1:0] n_lines,
    input  logic [PIX_W-1:0]  n_pix,
    input  logic [DIV_W-1:0]  rate_div,
    input  logic              clear_twice,
    output logic              ft_clk,
    output logic              v_clk,
    output logic              h_clk,
    output logic              shutter_open,
    output logic              pix_strobe,
    output logic              busy,
    output logic              done
);
    logic     rd_en;
    logic     tick;
    logic     first;
    ccd_drv_t drv;

    ccd_rate_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .en    (rd_en),
        .div   (rate_div),
        .tick  (tick),
        .first (first)
    );

    ccd_seq_fsm #(.EXP_W(EXP_W), .LINE_W(LINE_W), .PIX_W(PIX_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cap_req     (cap_req),
        .exp_len     (exp_len),
        .n_lines     (n_lines),
        .n_pix       (n_pix),
        .clear_twice (clear_twice),
        .tick        (tick),
        .first       (first),
        .rd_en       (rd_en),
        .drv         (drv),
        .busy        (busy),
        .done        (done)
    );

    assign ft_clk       = drv.ft;
    assign v_clk        = drv.vclk;
    assign h_clk        = drv.hclk;
    assign shutter_open = drv.shut;
    assign pix_strobe   = drv.strobe;

endmodule

// File: tb/sim_ccd_timing_seq.sv
module sim_ccd_timing_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cap_req = 1'b0;
    logic [15:0] exp_len = 16'd8;
    logic [7:0] n_lines = 8'd2;
    logic [7:0] n_pix = 8'd2;
    logic [7:0] rate_div = 8'd0;
    logic       clear_twice = 1'b0;
    logic       ft_clk, v_clk, h_clk, shutter_open, pix_strobe, busy, done;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ccd_timing_seq u0 (
        .clk(clk), .rst(rst), .cap_req(cap_req), .exp_len(exp_len),
        .n_lines(n_lines), .n_pix(n_pix), .rate_div(rate_div),
        .clear_twice(clear_twice), .ft_clk(ft_clk), .v_clk(v_clk),
        .h_clk(h_clk), .shutter_open(shutter_open), .pix_strobe(pix_strobe),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic wait_ft();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (ft_clk) break;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R2: shutter closed and all drives quiet in reset
        check({ft_clk, v_clk, h_clk, shutter_open, pix_strobe, busy, done} == 7'd0,
              "R2 reset outputs", {ft_clk, v_clk, h_clk, shutter_open, pix_strobe, busy, done}, 0);
        rst = 1'b0;
    endtask

    task automatic t_flush(input int nl);
        int period, vr, hr, lock_err, shut_err;
        bit pv, ph;
        n_lines = 8'(nl);
        wait_ft();
        wait_ft();
        period = 1; vr = 0; hr = 0; lock_err = 0; shut_err = 0; pv = 0; ph = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (ft_clk) break;
            period++;
            if (v_clk && !pv) vr++;
            if (h_clk && !ph) hr++;
            if (v_clk != h_clk || (i > 0 && v_clk == pv)) lock_err++;
            if (shutter_open) shut_err++;
            pv = v_clk; ph = h_clk;
        end
        check(period == 4 * eff(nl) + 1, "R4 flush period", period, 4 * eff(nl) + 1);
        check(period > 1, "R1 single-cycle ft", period, 4 * eff(nl) + 1);
        check(vr == 2 * eff(nl), "R3 vertical pulses per flush", vr, 2 * eff(nl));
        check(hr == vr, "R3 horizontal follows vertical", hr, vr);
        check(lock_err == 0, "R3 lockstep toggle", lock_err, 0);
        check(shut_err == 0, "R2 shutter closed in flush", shut_err, 0);
    endtask

    task automatic t_capture(input int el, input int nl, input int np, input int dv,
                             input bit dbl, input bit poke_busy);
        int ft_pre, open_c, ft_open, vh_open, vr, hr, sr, s_bad, w_bad, run, dcnt, shut_rd;
        int nle, npe, post_open;
        bit pv, ph, ps, busy_at_done;
        nle = eff(nl); npe = eff(np);
        exp_len = 16'(el); n_lines = 8'(nl); n_pix = 8'(np);
        rate_div = 8'(dv); clear_twice = dbl;
        wait_ft();
        wait_ft();
        repeat (2) @(negedge clk);
        cap_req = 1'b1;
        @(negedge clk);
        cap_req = 1'b0;
        check(busy == 1'b1, "R5 busy after request", busy, 1);
        ft_pre = 0;
        for (int i = 0; i < 20000; i++) begin
            if (shutter_open) break;
            if (ft_clk) ft_pre++;
            @(negedge clk);
        end
        check(ft_pre == (dbl ? 1 : 0), dbl ? "R6 extra clearing pass" : "R5 pass completes",
              ft_pre, dbl ? 1 : 0);
        open_c = 0; ft_open = 0; vh_open = 0;
        for (int i = 0; i < 70000; i++) begin
            if (!shutter_open) break;
            open_c++;
            if (ft_clk) ft_open++;
            if (v_clk || h_clk) vh_open++;
            @(negedge clk);
        end
        check(open_c == eff(el) + 1, "R7 shutter open length", open_c, eff(el) + 1);
        check(ft_open == 1 && vh_open == 0, "R7 clocks during exposure", ft_open * 10 + vh_open, 10);
        vr = 0; hr = 0; sr = 0; s_bad = 0; w_bad = 0; run = 0; shut_rd = 0;
        pv = 0; ph = 0; ps = 0; busy_at_done = 1;
        for (int i = 0; i < 20000; i++) begin
            if (poke_busy) begin
                if (i == 3) cap_req = 1'b1;
                if (i == 4) cap_req = 1'b0;
            end
            if (done) begin
                busy_at_done = busy;
                break;
            end
            if (shutter_open) shut_rd++;
            if (v_clk && !pv) vr++;
            if (h_clk && !ph) hr++;
            if (pix_strobe) begin
                sr++;
                if (h_clk || !ph || ps) s_bad++;
            end
            if (h_clk || v_clk) run++;
            else if (pv || ph) begin
                if (run != dv + 1) w_bad++;
                run = 0;
            end
            pv = v_clk; ph = h_clk; ps = pix_strobe;
            @(negedge clk);
        end
        cap_req = 1'b0;
        check(vr == nle, "R8 vertical pulses in readout", vr, nle);
        check(hr == nle * npe, "R8 horizontal pulses in readout", hr, nle * npe);
        check(w_bad == 0, "R9 pulse width", w_bad, 0);
        check(sr == nle * npe && s_bad == 0, "R10 strobe count and placement", sr * 100 + s_bad, nle * npe * 100);
        check(shut_rd == 0, "R2 shutter closed in readout", shut_rd, 0);
        check(done == 1'b1 && busy_at_done == 1'b0, "R11 busy falls with done", busy_at_done, 0);
        @(negedge clk);
        check(done == 1'b0, "R11 done single cycle", done, 0);
        if (poke_busy) begin
            post_open = 0;
            dcnt = 0;
            for (int i = 0; i < 2 * (4 * nle + 1) + 4; i++) begin
                if (shutter_open) post_open++;
                if (busy) dcnt++;
                @(negedge clk);
            end
            check(post_open == 0 && dcnt == 0, "R12 request while busy ignored", post_open + dcnt, 0);
        end
    endtask

    initial begin
        t_reset();
        t_flush(3);
        t_flush(1);
        t_flush(0);
        t_capture(10, 2, 3, 0, 1'b0, 1'b0);
        t_capture(5, 3, 2, 3, 1'b0, 1'b0);
        t_capture(0, 1, 0, 1, 1'b1, 1'b0);
        t_capture(4, 1, 2, 0, 1'b0, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule